// File: doc/BRIEF.md
# Three-Channel Multi-Mode Timer Bank

This block holds three 32-bit timers that share one register bus and one control/status word. Each timer has a single pin that is either an output or an input, depending on its mode. In waveform mode the timer drives a pulse train with a programmable period and high time. In capture mode it measures the high time and the full period of an incoming signal. In watchdog mode it counts active edges on its pin and raises an event once a programmed number of edges has arrived.

Software programs each timer through four registers: configuration, count, period and width. A shared word turns the timers on and off one by one. It also holds sticky per-timer event flags and overflow flags, which are cleared by writing 1. Each timer has its own interrupt line, which is the timer's sticky flag gated by its interrupt-enable bit.

The register bus is a plain single-cycle port with no wait states and no back-pressure. A write with `bus_sel` and `bus_we` high takes effect at the next rising clock edge. A read returns `bus_rdata` combinationally in the same cycle. The pad is split into an input, an output and an output enable, because the tri-state driver lies outside the block. The pin inputs pass through a two-stage synchronizer before any edge is seen.

Top module: `gp_timer_bank`

## Requirements
- R1: Each timer advances only while its enable bit (bit i of the control word) is 1. A disabled timer keeps its count, and other timers run or stop without affecting it.
- R2: Register addresses are word addresses. Timer i uses address 4*i+0 for configuration, 4*i+1 for count, 4*i+2 for period and 4*i+3 for width. Address 12 is the control/status word. In the configuration register, bits 1:0 are the mode (0 waveform, 1 capture, 2 watchdog, 3 idle), bit 2 is polarity and bit 3 is interrupt enable. Bits 5:4 always read back as 0. All registers reset to 0.
- R3: In the control/status word, bits 2:0 are the enables (read/write), bits 10:8 are the sticky event flags and bits 18:16 are the overflow flags. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R4: A timer drives its pin (output enable high) only while it is enabled in waveform mode. In every other case the output enable is low, the pin output is 0, and the pin is only sampled.
- R5: In waveform mode with period P (P≥1) and width W, the count runs 0..P-1 and then wraps to 0, giving one event per wrap. The pin is high while count < W, so it is high for W cycles out of every P.
- R6: Polarity 1 inverts the waveform output. In capture and watchdog modes, polarity 1 makes the falling pin edge the active edge in place of the rising edge.
- R7: In capture mode, the first active edge after enabling only restarts the count. After that, each inactive edge stores the high time in cycles into the width register. Each later active edge stores the full period in cycles into the period register, restarts the count and raises an event.
- R8: In watchdog mode the count grows by one on each active pin edge. The edge that brings the count to the period value raises an event, sets the overflow flag and resets the count to 0.
- R9: An event sets the timer's sticky flag whatever the interrupt-enable bit holds. `tmr_irq[i]` is high exactly while flag i and interrupt-enable i are both 1.
- R10: A software write to a count register overrides any hardware update in the same cycle. Counting then continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tmr_pin_in | input | 3 | Pin level seen at each pad |
| tmr_pin_out | output | 3 | Pin level driven in waveform mode |
| tmr_pin_oe | output | 3 | Pad output enable per timer |
| tmr_irq | output | 3 | Interrupt line per timer |

## Verification
On every cycle the assertions check that:
- a disabled timer's count stays put;
- the pin is driven only in waveform mode;
- a waveform wrap returns the count to zero;
- a watchdog count moves only on an active edge;
- a sticky flag rises only after an event.

Only the bench scenarios can show the quantities that unfold over time: the measured high time and period in capture mode, the high-to-low duty over whole waveform periods, the edge count at which the watchdog fires, and the effect of polarity on each of these.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    MODE_PWM  = 2'd0,
    MODE_CAP  = 2'd1,
    MODE_WDOG = 2'd2,
    MODE_IDLE = 2'd3
  } tmr_mode_e;

  localparam int CFG_W   = 6;
  localparam int CFG_USE = 4;
  localparam int REG_CFG = 0;
  localparam int REG_CNT = 1;
  localparam int REG_PER = 2;
  localparam int REG_WID = 3;
  localparam int ST_IRQ  = 8;
  localparam int ST_OVF  = 16;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic inv_i,
  output logic act_o,
  output logic inact_o
);
  logic [STAGES-1:0] sh;
  logic              prev;
  logic              lvl, lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], pin_i};
      prev <= sh[STAGES-1];
    end
  end

  assign lvl      = sh[STAGES-1] ^ inv_i;
  assign lvl_prev = prev ^ inv_i;
  assign act_o    = lvl & ~lvl_prev;
  assign inact_o  = ~lvl & lvl_prev;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import gpt_pkg::*;
#(
  parameter int CW   = 32,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             wr_cfg_i,
  input  logic             wr_cnt_i,
  input  logic             wr_per_i,
  input  logic             wr_wid_i,
  input  logic [CW-1:0]    wdata_i,
  input  logic             pin_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [CW-1:0]    cnt_o,
  output logic [CW-1:0]    per_o,
  output logic [CW-1:0]    wid_o,
  output logic             evt_o,
  output logic             ovf_o,
  output logic             act_o,
  output logic             pin_o,
  output logic             oe_o
);
  logic [CFG_USE-1:0] cfg;
  logic [CW-1:0]      cnt, per, wid;
  logic [CW-1:0]      cnt_nx, per_nx, wid_nx;
  logic               armed, armed_nx;
  logic               act, inact, reach, pol;
  tmr_mode_e          mode;

  assign mode  = tmr_mode_e'(cfg[1:0]);
  assign pol   = cfg[2];
  assign reach = ({1'b0, cnt} + 1'b1) >= {1'b0, per};

  tmr_pin_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .inv_i(pol),
    .act_o(act), .inact_o(inact)
  );

  always_comb begin
    cnt_nx   = cnt;
    per_nx   = per;
    wid_nx   = wid;
    armed_nx = armed;
    evt_o    = 1'b0;
    ovf_o    = 1'b0;
    if (en_i) begin
      case (mode)
        MODE_PWM: begin
          if (reach) begin
            cnt_nx = '0;
            evt_o  = 1'b1;
          end else begin
            cnt_nx = cnt + 1'b1;
          end
        end
        MODE_CAP: begin
          cnt_nx = cnt + 1'b1;
          if (act) begin
            if (armed) begin
              per_nx = cnt + 1'b1;
              evt_o  = 1'b1;
            end
            cnt_nx   = '0;
            armed_nx = 1'b1;
          end else if (inact && armed) begin
            wid_nx = cnt + 1'b1;
          end
        end
        MODE_WDOG: begin
          if (act) begin
            if (reach) begin
              cnt_nx = '0;
              evt_o  = 1'b1;
              ovf_o  = 1'b1;
            end else begin
              cnt_nx = cnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else begin
      armed_nx = 1'b0;
    end
    if (wr_cnt_i) cnt_nx = wdata_i;
    if (wr_per_i) per_nx = wdata_i;
    if (wr_wid_i) wid_nx = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      cnt   <= '0;
      per   <= '0;
      wid   <= '0;
      armed <= 1'b0;
    end else begin
      if (wr_cfg_i) cfg <= wdata_i[CFG_USE-1:0];
      cnt   <= cnt_nx;
      per   <= per_nx;
      wid   <= wid_nx;
      armed <= armed_nx;
    end
  end

  assign oe_o  = en_i && (mode == MODE_PWM);
  assign pin_o = oe_o ? ((cnt < wid) ^ pol) : 1'b0;
  assign act_o = act;
  assign cfg_o = {{(CFG_W-CFG_USE){1'b0}}, cfg};
  assign cnt_o = cnt;
  assign per_o = per;
  assign wid_o = wid;
endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
  import gpt_pkg::*;
#(
  parameter int N    = 3,
  parameter int CW   = 32,
  parameter int AW   = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic [N-1:0]  tmr_pin_in,
  output logic [N-1:0]  tmr_pin_out,
  output logic [N-1:0]  tmr_pin_oe,
  output logic [N-1:0]  tmr_irq
);
  localparam int IW = AW - 2;

  logic [IW-1:0]             idx;
  logic [1:0]                sub;
  logic                      wr, ctl_wr;
  logic [N-1:0]              en, sticky, ovf_st;
  logic [N-1:0]              evt, ovf_ev, act, ie;
  logic [N-1:0]              wr_cfg, wr_cnt, wr_per, wr_wid;
  logic [N-1:0][CFG_W-1:0]   cfg;
  logic [N-1:0][CW-1:0]      cnt, per, wid;
  logic [N-1:0][1:0]         mode;
  logic [CW-1:0]             status;

  assign idx    = bus_addr[AW-1:2];
  assign sub    = bus_addr[1:0];
  assign wr     = bus_sel && bus_we;
  assign ctl_wr = wr && (idx == IW'(N)) && (sub == 2'd0);

  for (genvar i = 0; i < N; i++) begin : g_tmr
    logic hit;
    assign hit       = wr && (idx == IW'(i));
    assign wr_cfg[i] = hit && (sub == 2'(REG_CFG));
    assign wr_cnt[i] = hit && (sub == 2'(REG_CNT));
    assign wr_per[i] = hit && (sub == 2'(REG_PER));
    assign wr_wid[i] = hit && (sub == 2'(REG_WID));

    tmr_unit #(.CW(CW), .SYNC(SYNC)) u_unit (
      .clk(clk), .rst_n(rst_n), .en_i(en[i]),
      .wr_cfg_i(wr_cfg[i]), .wr_cnt_i(wr_cnt[i]),
      .wr_per_i(wr_per[i]), .wr_wid_i(wr_wid[i]),
      .wdata_i(bus_wdata), .pin_i(tmr_pin_in[i]),
      .cfg_o(cfg[i]), .cnt_o(cnt[i]), .per_o(per[i]), .wid_o(wid[i]),
      .evt_o(evt[i]), .ovf_o(ovf_ev[i]), .act_o(act[i]),
      .pin_o(tmr_pin_out[i]), .oe_o(tmr_pin_oe[i])
    );

    assign ie[i]   = cfg[i][3];
    assign mode[i] = cfg[i][1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sticky[i] <= 1'b0;
        ovf_st[i] <= 1'b0;
      end else begin
        sticky[i] <= evt[i] | (sticky[i] & ~(ctl_wr & bus_wdata[ST_IRQ+i]));
        ovf_st[i] <= ovf_ev[i] | (ovf_st[i] & ~(ctl_wr & bus_wdata[ST_OVF+i]));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else if (ctl_wr) en <= bus_wdata[N-1:0];
  end

  assign tmr_irq = sticky & ie;

  always_comb begin
    status = '0;
    status[N-1:0]          = en;
    status[ST_IRQ+N-1:ST_IRQ] = sticky;
    status[ST_OVF+N-1:ST_OVF] = ovf_st;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (idx == IW'(N)) begin
        if (sub == 2'd0) bus_rdata = status;
      end else begin
        for (int i = 0; i < N; i++) begin
          if (idx == IW'(i)) begin
            case (sub)
              2'(REG_CFG): bus_rdata = CW'(cfg[i]);
              2'(REG_CNT): bus_rdata = cnt[i];
              2'(REG_PER): bus_rdata = per[i];
              default:     bus_rdata = wid[i];
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
  parameter int N  = 3,
  parameter int CW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         en,
  input logic [N-1:0][1:0]    mode,
  input logic [N-1:0][CW-1:0] cnt,
  input logic [N-1:0]         evt,
  input logic [N-1:0]         act,
  input logic [N-1:0]         wr_cnt,
  input logic [N-1:0]         sticky,
  input logic [N-1:0]         pin_oe
);
  for (genvar i = 0; i < N; i++) begin : g_chk
    p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !wr_cnt[i]) |=> $stable(cnt[i]));

    p_oe_pwm_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[i] |-> (en[i] && mode[i] == 2'd0));

    p_pwm_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en[i] && mode[i] == 2'd0 && evt[i] && !wr_cnt[i]) |=> (cnt[i] == '0));

    p_wdog_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en[i] && mode[i] == 2'd2 && !act[i] && !wr_cnt[i]) |=> $stable(cnt[i]));

    p_sticky_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sticky[i]) |-> $past(evt[i]));
  end
endmodule

bind gp_timer_bank gpt_checker #(.N(N), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cnt(cnt),
  .evt(evt), .act(act), .wr_cnt(wr_cnt), .sticky(sticky), .pin_oe(tmr_pin_oe)
);

// File: tb/sim_gp_timer_bank.sv
module sim_gp_timer_bank;
  localparam int CLK_P = 10;
  localparam logic [3:0] CTL = 4'd12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  tmr_pin_in = '0;
  logic [2:0]  tmr_pin_out, tmr_pin_oe, tmr_irq;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gp_timer_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_pin_in(tmr_pin_in), .tmr_pin_out(tmr_pin_out),
    .tmr_pin_oe(tmr_pin_oe), .tmr_irq(tmr_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(CTL, v);        chk("R3 reset ctl", v, 32'h0);
    rd(4'd2, v);       chk("R2 reset period", v, 32'h0);
    chk("R4 reset oe", 32'(tmr_pin_oe), 32'h0);
    chk("R9 reset irq", 32'(tmr_irq), 32'h0);
  endtask

  task automatic t_cfg_reserved;
    logic [31:0] v;
    wr(4'd4, 32'h3F);
    rd(4'd4, v); chk("R2 cfg reserved bits", v, 32'h0F);
    wr(4'd4, 32'h0);
  endtask

  task automatic t_pwm(input logic pol);
    int ones = 0;
    logic [31:0] v;
    wr(4'd2, 32'd5); wr(4'd3, 32'd2); wr(4'd1, 32'd0);
    wr(4'd0, {28'd0, 1'b1, pol, 2'd0});
    wr(CTL, 32'h1);
    chk("R4 oe in waveform", 32'(tmr_pin_oe[0]), 32'h1);
    for (int k = 0; k < 10; k++) begin
      ones += int'(tmr_pin_out[0]);
      @(negedge clk);
    end
    chk(pol ? "R6 inverted duty" : "R5 duty", 32'(ones), pol ? 32'd6 : 32'd4);
    wr(CTL, 32'h0);
    chk("R9 irq with ie", 32'(tmr_irq[0]), 32'h1);
    rd(CTL, v); chk("R3 sticky flag set", v & 32'h100, 32'h100);
    wr(CTL, 32'h100);
    rd(CTL, v); chk("R3 flag cleared by 1", v & 32'h100, 32'h0);
  endtask

  task automatic t_independent;
    logic [31:0] a0, b0, a1, b1;
    wr(4'd6, 32'd1000); wr(4'd5, 32'd0); wr(4'd4, 32'h0);
    wr(CTL, 32'h2);
    rd(4'd1, a0); rd(4'd5, a1);
    repeat (10) @(negedge clk);
    rd(4'd1, b0); rd(4'd5, b1);
    chk("R1 disabled timer holds", b0, a0);
    chk("R1 enabled timer advances", b1 - a1, 32'd10);
    wr(CTL, 32'h0);
  endtask

  task automatic t_cnt_write;
    logic [31:0] v;
    wr(4'd2, 32'd1000); wr(4'd0, 32'h0);
    wr(CTL, 32'h1);
    wr(4'd1, 32'd500);
    rd(4'd1, v); chk("R10 count write wins", v, 32'd500);
    repeat (3) @(negedge clk);
    rd(4'd1, v); chk("R10 count continues", v, 32'd503);
    wr(CTL, 32'h0);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    wr(4'd8, 32'h9);
    wr(CTL, 32'h4);
    repeat (4) @(negedge clk);
    chk("R4 no drive in capture", 32'(tmr_pin_oe[2]), 32'h0);
    tmr_pin_in[2] = 1'b1;
    repeat (3) @(negedge clk);
    tmr_pin_in[2] = 1'b0;
    repeat (5) @(negedge clk);
    rd(CTL, v); chk("R7 first edge only arms", v & 32'h400, 32'h0);
    tmr_pin_in[2] = 1'b1;
    repeat (6) @(negedge clk);
    rd(4'd11, v); chk("R7 captured width", v, 32'd3);
    rd(4'd10, v); chk("R7 captured period", v, 32'd8);
    rd(CTL, v);   chk("R7 capture event", v & 32'h400, 32'h400);
    chk("R9 capture irq", 32'(tmr_irq[2]), 32'h1);
    wr(CTL, 32'h400);
  endtask

  task automatic pulse1;
    tmr_pin_in[1] = 1'b1; repeat (2) @(negedge clk);
    tmr_pin_in[1] = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic t_wdog;
    logic [31:0] v;
    wr(4'd6, 32'd3); wr(4'd5, 32'd0);
    wr(4'd4, 32'h6);
    wr(CTL, 32'h2);
    repeat (3) @(negedge clk);
    pulse1(); pulse1();
    repeat (4) @(negedge clk);
    rd(4'd5, v);  chk("R8 falling edges counted", v, 32'd2);
    rd(CTL, v);   chk("R8 no event yet", v & 32'h20200, 32'h0);
    tmr_pin_in[1] = 1'b1; repeat (4) @(negedge clk);
    rd(4'd5, v);  chk("R6 rising edge inactive", v, 32'd2);
    tmr_pin_in[1] = 1'b0; repeat (4) @(negedge clk);
    rd(4'd5, v);  chk("R8 count reset on event", v, 32'd0);
    rd(CTL, v);   chk("R8 event and overflow", v & 32'h20200, 32'h20200);
    chk("R9 no irq without ie", 32'(tmr_irq[1]), 32'h0);
    wr(CTL, 32'h20000);
    rd(CTL, v);   chk("R3 overflow cleared, flag kept", v & 32'h20200, 32'h200);
    wr(CTL, 32'h200);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_reserved();
    t_pwm(1'b0);
    t_pwm(1'b1);
    t_independent();
    t_cnt_write();
    t_capture();
    t_wdog();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule